// File: doc/BRIEF.md
# Framed Word Serializer with Training Burst

This block turns a 10-bit parallel word into a 12-bit serial frame. Every frame opens with a 1, carries the data bits least significant first, and closes with a 0. The guaranteed 0-to-1 step at each frame boundary gives a receiver an embedded clock edge to align to. All logic runs on one bit clock. A free-running counter splits that clock into 12-cycle word slots, so the serial rate is twelve times the word rate and ten bits of each twelve carry payload.

The parallel word is paced by a slower word clock. That clock is resynchronized into the bit-clock domain, and a select input picks which of its edges captures the data. Two training-request inputs are ORed together. When the OR has been high for six word slots in a row, the block stops sending data and sends a burst of 1026 training frames. Each training frame is six 1 bits followed by six 0 bits. While the request stays high past the end of the burst, training frames continue. After the request drops, a fresh hold of six slots starts a new burst.

A pad-enable output models the high-impedance state. A power-down input stops the block. After power-down is released, the block waits through an initialization period before it sends its first frame.

Top module: `ser_frame_tx`

## Requirements
- R1: Each frame lasts 12 bit-clock cycles on `ser_o`, one bit per cycle. The order is: a 1, then `din_i[0]` through `din_i[9]`, then a 0.
- R2: With `edge_rise_i` high, the word is taken on the rising edge of `word_clk_i`. With it low, the word is taken on the falling edge.
- R3: The training request is `sync_a_i | sync_b_i`, sampled once per word slot. If it is high for fewer than 6 consecutive slots, no training frame is sent. If it is high for exactly 6, a burst starts.
- R4: A burst is exactly 1026 consecutive training frames, sent bit 0 first with bits 0 to 5 at 1 and bits 6 to 11 at 0. No data frame appears in its place, whatever `din_i` does.
- R5: If the request is still high when the burst ends, training frames continue, one per slot, until the request drops. A new hold of 6 slots after the drop starts another burst of 1026.
- R6: `oe_o` is high only when `en_i` and `pd_ni` are high, both training-request inputs are low, and frames are being sent. `en_i` has no effect on the serial stream itself.
- R7: While `rst_ni` is low, or one cycle after `pd_ni` is sampled low, `ser_o`, `oe_o` and `vld_o` are all 0.
- R8: After reset or power-down is released, no frame is sent for the first 1026 word slots. `vld_o` rises within the two slots that follow.
- R9: `vld_o` rises only on the cycle after a frame has been loaded into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_clk_i | input | 1 | Word-rate clock, resynchronized inside |
| edge_rise_i | input | 1 | 1: capture on rising word-clock edge, 0: on falling edge |
| din_i | input | DW | Parallel data word |
| sync_a_i | input | 1 | Training request, first source |
| sync_b_i | input | 1 | Training request, second source |
| en_i | input | 1 | Pad enable |
| pd_ni | input | 1 | Power-down, active low |
| ser_o | output | 1 | Serial data |
| oe_o | output | 1 | Pad drive enable (0 models high impedance) |
| vld_o | output | 1 | Frame shifter active |

## Verification
The word input is driven with a different value in each half of the word clock. The frame that appears on the line therefore shows which edge captured it, and a reversed or misframed bit order leaves no matching 12-bit window in the stream. Training requests are driven for exactly five slots and exactly six slots, once on each input, which separates the qualification threshold from an off-by-one. The 111111000000 windows are counted to pin the burst at 1026. A 1100-slot hold followed by a new 6-slot pulse separates extension of a held request from retriggering. Changing the data in the middle of a burst checks that the burst ignores `din_i`.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned FRAME_OVH = 2;
  typedef enum logic {FK_DATA = 1'b0, FK_SYNC = 1'b1} frame_kind_e;
endpackage

// File: rtl/ser_word_capture.sv
module ser_word_capture #(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          word_clk_i,
  input  logic          edge_rise_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] word_o
);
  logic [2:0] wsync_q;
  logic       cap;

  // wsync_q[1] is the settled copy, wsync_q[2] the previous one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wsync_q <= '0;
    else         wsync_q <= {wsync_q[1:0], word_clk_i};
  end

  assign cap = edge_rise_i ? (wsync_q[1] & ~wsync_q[2])
                           : (~wsync_q[1] & wsync_q[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_o <= '0;
    else if (!run_i) word_o <= '0;
    else if (cap)    word_o <= din_i;
  end
endmodule

// File: rtl/ser_bit_timer.sv
module ser_bit_timer #(
  parameter int unsigned FRAME_W    = 12,
  parameter int unsigned INIT_WORDS = 1026
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic word_stb_o,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(FRAME_W);
  localparam int unsigned IW = $clog2(INIT_WORDS + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [CW-1:0] cnt_q;
  logic [IW-1:0] init_q;

  assign word_stb_o = run_i && (cnt_q == LAST);
  assign ready_o    = (init_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      init_q <= IW'(INIT_WORDS);
    end else if (!run_i) begin
      cnt_q  <= '0;
      init_q <= IW'(INIT_WORDS);
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (word_stb_o && init_q != '0) init_q <= init_q - 1'b1;
    end
  end
endmodule

// File: rtl/ser_sync_ctrl.sv
module ser_sync_ctrl
  import ser_pkg::*;
#(
  parameter int unsigned QUAL  = 6,
  parameter int unsigned BURST = 1026
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        step_i,
  input  logic        req_i,
  output frame_kind_e kind_o
);
  localparam int unsigned QW = $clog2(QUAL + 1);
  localparam int unsigned BW = $clog2(BURST + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL);
  localparam logic [QW-1:0] QHIT = QW'(QUAL - 1);

  logic [QW-1:0] qual_q;
  logic [BW-1:0] left_q;
  logic          hit, held;

  assign hit    = req_i && (qual_q == QHIT);
  assign held   = req_i && (qual_q == QMAX);
  assign kind_o = (hit || held || left_q != '0) ? FK_SYNC : FK_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q <= '0;
      left_q <= '0;
    end else if (!run_i) begin
      qual_q <= '0;
      left_q <= '0;
    end else if (step_i) begin
      if (!req_i)             qual_q <= '0;
      else if (qual_q != QMAX) qual_q <= qual_q + 1'b1;
      if (hit)                left_q <= BW'(BURST - 1);
      else if (left_q != '0)  left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift
  import ser_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          load_i,
  input  frame_kind_e   kind_i,
  input  logic [DW-1:0] word_i,
  output logic          ser_o,
  output logic          vld_o
);
  localparam int unsigned FW = DW + FRAME_OVH;
  localparam logic [FW-1:0] SYNC_PAT = {{(FW - FW/2){1'b0}}, {(FW/2){1'b1}}};

  logic [FW-1:0] sh_q;
  logic [FW-1:0] frame;

  // bit 0 leaves first: start bit, payload LSB first, stop bit
  assign frame = (kind_i == FK_SYNC) ? SYNC_PAT : {1'b0, word_i, 1'b1};
  assign ser_o = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      vld_o <= 1'b0;
    end else if (!run_i) begin
      sh_q  <= '0;
      vld_o <= 1'b0;
    end else if (load_i) begin
      sh_q  <= frame;
      vld_o <= 1'b1;
    end else begin
      sh_q <= {1'b0, sh_q[FW-1:1]};
    end
  end
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ser_pkg::*;
#(
  parameter int unsigned DW         = 10,
  parameter int unsigned SYNC_QUAL  = 6,
  parameter int unsigned SYNC_BURST = 1026,
  parameter int unsigned INIT_WORDS = 1026
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          word_clk_i,
  input  logic          edge_rise_i,
  input  logic [DW-1:0] din_i,
  input  logic          sync_a_i,
  input  logic          sync_b_i,
  input  logic          en_i,
  input  logic          pd_ni,
  output logic          ser_o,
  output logic          oe_o,
  output logic          vld_o
);
  localparam int unsigned FW = DW + FRAME_OVH;

  logic          word_stb, ready, frame_load, sync_req;
  logic [DW-1:0] word;
  frame_kind_e   kind;

  assign sync_req   = sync_a_i | sync_b_i;
  assign frame_load = word_stb & ready;

  ser_word_capture #(.DW(DW)) u_cap (
    .clk_i, .rst_ni, .run_i(pd_ni), .word_clk_i, .edge_rise_i,
    .din_i, .word_o(word)
  );

  ser_bit_timer #(.FRAME_W(FW), .INIT_WORDS(INIT_WORDS)) u_tmr (
    .clk_i, .rst_ni, .run_i(pd_ni), .word_stb_o(word_stb), .ready_o(ready)
  );

  ser_sync_ctrl #(.QUAL(SYNC_QUAL), .BURST(SYNC_BURST)) u_sync (
    .clk_i, .rst_ni, .run_i(pd_ni), .step_i(frame_load), .req_i(sync_req),
    .kind_o(kind)
  );

  ser_frame_shift #(.DW(DW)) u_shf (
    .clk_i, .rst_ni, .run_i(pd_ni), .load_i(frame_load), .kind_i(kind),
    .word_i(word), .ser_o, .vld_o
  );

  assign oe_o = en_i & pd_ni & ~sync_req & vld_o;
endmodule

// File: rtl/ser_frame_tx_chk.sv
module ser_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic pd_ni,
  input logic sync_a_i,
  input logic sync_b_i,
  input logic ser_o,
  input logic oe_o,
  input logic vld_o,
  input logic word_stb,
  input logic frame_load
);
  // R6
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (en_i && pd_ni && !sync_a_i && !sync_b_i));

  // R7
  pd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (!vld_o && !oe_o && !ser_o));

  // R1
  first_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frame_load) && vld_o) |-> ser_o);

  // R1
  last_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb && vld_o) |-> !ser_o);

  // R9
  vld_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_o) |-> $past(frame_load));
endmodule

bind ser_frame_tx ser_frame_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .pd_ni(pd_ni),
  .sync_a_i(sync_a_i), .sync_b_i(sync_b_i), .ser_o(ser_o), .oe_o(oe_o),
  .vld_o(vld_o), .word_stb(word_stb), .frame_load(frame_load)
);

// File: tb/tb_ser_frame_tx.sv
module tb_ser_frame_tx;
  localparam int CLK_P = 10;
  localparam int WP    = 12;
  localparam int NV    = 6;
  // {edge_rise, word in high half, word in low half}
  localparam logic [20:0] VECS [NV] = '{
    {1'b1, 10'h2B4, 10'h0F1}, {1'b0, 10'h2B4, 10'h0F1},
    {1'b1, 10'h001, 10'h200}, {1'b0, 10'h001, 10'h200},
    {1'b1, 10'h155, 10'h2AA}, {1'b0, 10'h3C3, 10'h03C}
  };

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       word_clk, edge_rise = 1'b1;
  logic [9:0] din;
  logic       sync_a = 1'b0, sync_b = 1'b0, en = 1'b1, pd_n = 1'b1;
  logic       ser, oe, vld;

  logic [9:0]  cur_a = 10'h3FF, cur_b = 10'h3FF;
  logic [11:0] win = '0, want = '0;
  logic        hit = 1'b0;
  int          sync_seen = 0, checks = 0, fails = 0, wc_ph = 0;

  ser_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_clk_i(word_clk), .edge_rise_i(edge_rise),
    .din_i(din), .sync_a_i(sync_a), .sync_b_i(sync_b), .en_i(en), .pd_ni(pd_n),
    .ser_o(ser), .oe_o(oe), .vld_o(vld)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    word_clk = 1'b0;
    din = '0;
    forever begin
      @(negedge clk);
      if (wc_ph == 0) begin word_clk = 1'b1; din = cur_a; end
      else if (wc_ph == WP/2) begin word_clk = 1'b0; din = cur_b; end
      wc_ph = (wc_ph == WP-1) ? 0 : wc_ph + 1;
    end
  end

  always @(negedge clk) begin
    win = {win[10:0], ser};
    if (win == 12'hFC0) sync_seen = sync_seen + 1;
    if (win == want) hit = 1'b1;
  end

  function automatic logic [11:0] frame_win(input logic [9:0] w);
    logic [11:0] r;
    r = '0;
    r[11] = 1'b1;
    for (int j = 0; j < 10; j++) r[10-j] = w[j];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_init(input string tag);
    int n;
    n = 0;
    while (!vld && n < 1030*WP) begin @(negedge clk); n++; end
    chk(n > 1026*WP && n <= 1028*WP, tag, n, 1027*WP);
  endtask

  task automatic pulse(input bit which, input int cyc);
    if (which) sync_b = 1'b1; else sync_a = 1'b1;
    wait_clk(cyc);
    sync_a = 1'b0;
    sync_b = 1'b0;
  endtask

  initial begin
    wait_clk(3);
    // R7 reset state
    chk(!ser && !oe && !vld, "R7 reset", {ser, oe, vld}, 0);
    rst_ni = 1'b1;
    // R8 initialization wait after reset
    measure_init("R8 init after reset");
    wait_clk(2);
    chk(oe, "R6 oe after init", oe, 1);

    // R1 / R2 frame format and capture edge
    for (int i = 0; i < NV; i++) begin
      edge_rise = VECS[i][20];
      cur_a = VECS[i][19:10];
      cur_b = VECS[i][9:0];
      want = frame_win(edge_rise ? cur_a : cur_b);
      wait_clk(3*WP);
      hit = 1'b0;
      wait_clk(4*WP);
      chk(hit, edge_rise ? "R1 R2 rising capture" : "R1 R2 falling capture",
          hit, 1);
    end

    // R6 enable gates only the pad
    en = 1'b0;
    hit = 1'b0;
    wait_clk(3*WP);
    chk(!oe, "R6 oe with en low", oe, 0);
    chk(hit, "R6 stream kept with en low", hit, 1);
    en = 1'b1;
    wait_clk(2);
    chk(oe, "R6 oe restored", oe, 1);

    cur_a = 10'h3FF;
    cur_b = 10'h3FF;
    want = 12'h000;
    wait_clk(3*WP);

    // R3 five-slot request is rejected
    sync_seen = 0;
    sync_a = 1'b1;
    wait_clk(2*WP);
    chk(!oe, "R6 oe low during request", oe, 0);
    wait_clk(3*WP);
    sync_a = 1'b0;
    wait_clk(30*WP);
    chk(sync_seen == 0, "R3 short request", sync_seen, 0);

    // R3 R4 six-slot request on second input, data changed mid burst
    sync_seen = 0;
    pulse(1'b1, 6*WP);
    cur_a = 10'h2B4;
    cur_b = 10'h2B4;
    want = frame_win(10'h2B4);
    wait_clk(4*WP);
    hit = 1'b0;
    wait_clk(990*WP);
    chk(!hit, "R4 data ignored in burst", hit, 0);
    cur_a = 10'h3FF;
    cur_b = 10'h3FF;
    want = 12'h000;
    wait_clk(60*WP);
    chk(sync_seen == 1026, "R4 burst length", sync_seen, 1026);

    // R5 held request extends past the burst
    sync_seen = 0;
    pulse(1'b0, 1100*WP);
    wait_clk(20*WP);
    chk(sync_seen == 1095, "R5 extension", sync_seen, 1095);

    // R5 retrigger after drop
    sync_seen = 0;
    pulse(1'b0, 6*WP);
    wait_clk(1040*WP);
    chk(sync_seen == 1026, "R5 retrigger", sync_seen, 1026);

    // R7 power-down, R8 reinitialization
    pd_n = 1'b0;
    wait_clk(3);
    chk(!vld, "R7 pd vld", vld, 0);
    chk(!oe, "R7 pd oe", oe, 0);
    chk(!ser, "R7 pd ser", ser, 0);
    pd_n = 1'b1;
    measure_init("R8 init after power-down");
    want = frame_win(10'h3FF);
    hit = 1'b0;
    wait_clk(3*WP);
    chk(hit, "R1 frame after power-down", hit, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule